// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This block decides, for a small 8-bit processor core, when an interrupt is launched and where execution goes. It keeps a 5-bit request register, which event sources set through one-cycle pulses. The current contents of the interrupt enable register arrive on an input. A source is pending when its request bit and its enable bit are both set. The block also holds the master interrupt enable. The instruction decoder changes that flag with enable, disable and return-from-interrupt strobes.

At every instruction boundary that the core signals, the controller checks whether a dispatch can start. Four things must hold: some source is pending, the master enable is set, no earlier dispatch is still waiting for the core's acknowledge, and no entry sequence is running. If so, it emits a one-cycle dispatch pulse and a restart vector. In the same edge it clears the master enable and clears only the request bit it is servicing. The lowest-numbered pending bit wins, and each vector lies 8 bytes above the previous one, starting at 0x0040.

While the entry sequence runs, an entry window output stalls the core. A wake output ends the halt state whenever the core is halted and a source is pending. This happens even when the master enable is off, in which case the core wakes but nothing is dispatched. The stack push, timers and the rest of the core lie outside this block.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: During reset and after it is released: `ime_o`=0, `req_o`=0, `dispatch_o`=0, `busy_o`=0, `entry_o`=0 and `vector_o`=0x0000.
- R2: A dispatch starts at a clock edge when all of the following hold: `boundary_i`=1, (`req_o` & `enable_i`) is non-zero, `ime_o`=1, `busy_o`=0 and `entry_o`=0. In the next cycle `dispatch_o` is 1 for exactly one cycle and `ime_o` reads 0.
- R3: The vector latched at a dispatch is 0x0040 + 8*k, where k is the index of the lowest set bit of (`req_o` & `enable_i`). Bit 0 has the highest priority. The vector holds its value until the next dispatch.
- R4: `wake_o` is combinationally `halted_i` AND (any bit of `req_o` & `enable_i`), whatever the value of `ime_o`. When `ime_o`=0, no dispatch occurs.
- R5: `di_i` clears `ime_o` from the next cycle, and `ei_i` or `reti_i` sets it from the next cycle. `di_i` wins over `ei_i` and `reti_i`, and a dispatch clears the flag over any strobe.
- R6: `entry_o` is 1 for exactly 4 cycles (ENTRY_CYCLES), starting with the cycle in which `dispatch_o` is 1.
- R7: `req_set_i` bits are ORed into `req_o` at the next edge. A dispatch clears only the serviced bit, and lower-priority bits stay set. A set pulse on the serviced bit in the dispatch cycle keeps that bit set.
- R8: `busy_o` rises with `dispatch_o` and falls after the edge at which `dispatch_ack_i`=1. While `busy_o`=1 no new dispatch occurs. `dispatch_ack_i` has no effect while `busy_o`=0.
- R9: Requests are never dispatched at an edge where `boundary_i`=0, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 5 | Current contents of the interrupt enable register |
| req_set_i | input | 5 | One-cycle pulses that set request bits |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| halted_i | input | 1 | Core is in the halt state |
| ei_i | input | 1 | Decoder strobe: set master enable |
| di_i | input | 1 | Decoder strobe: clear master enable |
| reti_i | input | 1 | Decoder strobe: return from interrupt, sets master enable |
| dispatch_ack_i | input | 1 | Core acknowledges the current dispatch |
| dispatch_o | output | 1 | One-cycle dispatch pulse |
| vector_o | output | 16 | Restart vector of the last dispatch |
| wake_o | output | 1 | Ends the halt state |
| entry_o | output | 1 | Entry window, core stalls fetch |
| busy_o | output | 1 | Dispatch awaiting acknowledge |
| ime_o | output | 1 | Master interrupt enable |
| req_o | output | 5 | Request register |

## Verification
The assertions take for granted that every strobe and the enable lines are driven to 0 or 1 in every cycle after reset. They also assume the core may raise `ei_i`, `di_i` and `reti_i` together, and may raise the acknowledge while nothing is outstanding. The stimulus draws all inputs from a seeded random source and drives each of them every cycle, including simultaneous conflicting strobes and stray acknowledges. Directed sequences add the full-priority case, wake with the master enable off, and set-versus-clear on the serviced bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    IME_HOLD = 2'd0,
    IME_SET  = 2'd1,
    IME_CLR  = 2'd2
  } ime_cmd_e;
endpackage

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] req_q, req_d;

  always_comb begin
    req_d = (req_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  // R7: at most one bit is cleared per dispatch
  assert_single_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));

  // R7: a cleared bit without a set pulse reads zero next cycle
  assert_clear_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((req_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N          = 5,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 'h40,
  parameter int VEC_STRIDE = 8
) (
  input  logic [N-1:0]      pend_i,
  output logic              any_o,
  output logic [N-1:0]      grant_o,
  output logic [ADDR_W-1:0] vec_o
);
  assign any_o = |pend_i;

  for (genvar g = 0; g < N; g++) begin : g_grant
    if (g == 0) begin : g_first
      assign grant_o[g] = pend_i[g];
    end else begin : g_rest
      assign grant_o[g] = pend_i[g] & ~(|pend_i[g-1:0]);
    end
  end

  always_comb begin
    vec_o = ADDR_W'(VEC_BASE);
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) vec_o = ADDR_W'(VEC_BASE + i * VEC_STRIDE);
    end
  end
endmodule

// File: rtl/irq_ime.sv
module irq_ime
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ime_cmd_e cmd_i,
  output logic     ime_o
);
  logic ime_q, ime_d;

  always_comb begin
    ime_d = ime_q;
    unique case (cmd_i)
      IME_SET: ime_d = 1'b1;
      IME_CLR: ime_d = 1'b0;
      default: ime_d = ime_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ime_q <= 1'b0;
    else        ime_q <= ime_d;
  end

  assign ime_o = ime_q;

  // R5: clear command takes effect on the next cycle
  assert_ime_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == IME_CLR) |=> !ime_o);
  // R5: set command takes effect on the next cycle
  assert_ime_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == IME_SET) |=> ime_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int ENTRY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic busy_o,
  output logic entry_o
);
  localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)             cnt_d = CNT_W'(ENTRY_CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    busy_d = busy_q;
    if (start_i)             busy_d = 1'b1;
    else if (ack_i)          busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign entry_o = (cnt_q != '0);
  assign busy_o  = busy_q;

  // R6: the entry window only opens after a start
  assert_entry_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && !$past(entry_o)) |-> $past(start_i));
  // R8: an acknowledge without a start drops busy
  assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !start_i) |=> !busy_o);
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_pkg::*;
#(
  parameter int N            = 5,
  parameter int ADDR_W       = 16,
  parameter int VEC_BASE     = 'h40,
  parameter int VEC_STRIDE   = 8,
  parameter int ENTRY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      enable_i,
  input  logic [N-1:0]      req_set_i,
  input  logic              boundary_i,
  input  logic              halted_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              reti_i,
  input  logic              dispatch_ack_i,
  output logic              dispatch_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              wake_o,
  output logic              entry_o,
  output logic              busy_o,
  output logic              ime_o,
  output logic [N-1:0]      req_o
);
  localparam int VEC_LAST = VEC_BASE + (N - 1) * VEC_STRIDE;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic [N-1:0]      pend, grant, clr_mask;
  logic              any_pend, take;
  logic [ADDR_W-1:0] vec_sel;
  ime_cmd_e          ime_cmd;
  logic              disp_q, disp_d;
  logic [ADDR_W-1:0] vec_q, vec_d;

  // reset assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  irq_req_reg #(.N(N)) u_req (
    .clk(clk), .rst_n(core_rst_n), .set_i(req_set_i),
    .clr_i(clr_mask), .req_o(req_o)
  );

  assign pend = req_o & enable_i;

  irq_pick #(.N(N), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
             .VEC_STRIDE(VEC_STRIDE)) u_pick (
    .pend_i(pend), .any_o(any_pend), .grant_o(grant), .vec_o(vec_sel)
  );

  assign take     = boundary_i & any_pend & ime_o & ~busy_o & ~entry_o;
  assign clr_mask = take ? grant : '0;
  assign wake_o   = halted_i & any_pend;

  always_comb begin
    if (take)                ime_cmd = IME_CLR;
    else if (di_i)           ime_cmd = IME_CLR;
    else if (ei_i || reti_i) ime_cmd = IME_SET;
    else                     ime_cmd = IME_HOLD;
  end

  irq_ime u_ime (
    .clk(clk), .rst_n(core_rst_n), .cmd_i(ime_cmd), .ime_o(ime_o)
  );

  irq_entry_seq #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_seq (
    .clk(clk), .rst_n(core_rst_n), .start_i(take),
    .ack_i(dispatch_ack_i), .busy_o(busy_o), .entry_o(entry_o)
  );

  always_comb begin
    disp_d = take;
    vec_d  = vec_q;
    if (take) vec_d = vec_sel;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      disp_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      disp_q <= disp_d;
      vec_q  <= vec_d;
    end
  end

  assign dispatch_o = disp_q;
  assign vector_o   = vec_q;

  // R2: a dispatch needs the master enable in the prior cycle and drops it
  assert_needs_ime_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    dispatch_o |-> ($past(ime_o) && !ime_o));
  // R3: dispatched vector lies within the vector range
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    dispatch_o |-> (vector_o >= ADDR_W'(VEC_BASE) && vector_o <= ADDR_W'(VEC_LAST)));
  // R8: no dispatch while a previous one awaits acknowledge
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    dispatch_o |-> !$past(busy_o));
  // R9: dispatch only follows a boundary strobe
  assert_at_boundary_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    dispatch_o |-> $past(boundary_i));
  // R6: entry window is open whenever a dispatch is issued
  assert_entry_with_disp_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    dispatch_o |-> entry_o);
endmodule

// File: tb/irq_dispatch_ctrl_test.sv
module irq_dispatch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  enable_i, req_set_i;
  logic        boundary_i, halted_i, ei_i, di_i, reti_i, dispatch_ack_i;
  logic        dispatch_o, wake_o, entry_o, busy_o, ime_o;
  logic [15:0] vector_o;
  logic [4:0]  req_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [4:0]  m_req;
  logic        m_ime, m_busy, m_disp;
  int          m_cnt;
  logic [15:0] m_vec;

  always #2 clk = ~clk;

  irq_dispatch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .req_set_i(req_set_i),
    .boundary_i(boundary_i), .halted_i(halted_i), .ei_i(ei_i), .di_i(di_i),
    .reti_i(reti_i), .dispatch_ack_i(dispatch_ack_i), .dispatch_o(dispatch_o),
    .vector_o(vector_o), .wake_o(wake_o), .entry_o(entry_o), .busy_o(busy_o),
    .ime_o(ime_o), .req_o(req_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return i;
    return 0;
  endfunction

  // one clock cycle with the given inputs, checked against the reference
  task automatic cycle(input logic [4:0] en, input logic [4:0] st, input logic bnd,
                       input logic hlt, input logic ei, input logic di,
                       input logic rt, input logic ack);
    logic [4:0] pend, sel;
    logic take;
    enable_i = en; req_set_i = st; boundary_i = bnd; halted_i = hlt;
    ei_i = ei; di_i = di; reti_i = rt; dispatch_ack_i = ack;
    #1;
    pend = m_req & en;
    chk("R4 wake", {15'd0, wake_o}, {15'd0, hlt & (|pend)});
    take = bnd & (|pend) & m_ime & ~m_busy & (m_cnt == 0);
    sel  = take ? (5'd1 << lowest(pend)) : 5'd0;
    @(posedge clk);
    @(negedge clk);
    m_req  = (m_req & ~sel) | st;
    m_ime  = take ? 1'b0 : di ? 1'b0 : (ei | rt) ? 1'b1 : m_ime;
    m_busy = take ? 1'b1 : ack ? 1'b0 : m_busy;
    m_cnt  = take ? 4 : (m_cnt != 0 ? m_cnt - 1 : 0);
    m_disp = take;
    if (take) m_vec = 16'h0040 + 16'(8 * lowest(pend));
    chk("R2/R9 dispatch", {15'd0, dispatch_o}, {15'd0, m_disp});
    chk("R3 vector", vector_o, m_vec);
    chk("R5 ime", {15'd0, ime_o}, {15'd0, m_ime});
    chk("R7 req", {11'd0, req_o}, {11'd0, m_req});
    chk("R8 busy", {15'd0, busy_o}, {15'd0, m_busy});
    chk("R6 entry", {15'd0, entry_o}, {15'd0, m_cnt != 0});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(5'h1f, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0;
    enable_i = '0; req_set_i = '0; boundary_i = 0; halted_i = 0;
    ei_i = 0; di_i = 0; reti_i = 0; dispatch_ack_i = 0;
    m_req = '0; m_ime = 0; m_busy = 0; m_disp = 0; m_cnt = 0; m_vec = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ime", {15'd0, ime_o}, 16'd0);
    chk("R1 req", {11'd0, req_o}, 16'd0);
    chk("R1 vector", vector_o, 16'd0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 dispatch", {15'd0, dispatch_o}, 16'd0);
    chk("R1 busy", {15'd0, busy_o}, 16'd0);

    // R4: pending with ime off wakes, no dispatch
    cycle(5'h1f, 5'h04, 0, 0, 0, 0, 0, 0);
    cycle(5'h1f, 5'h00, 1, 1, 0, 0, 0, 0);
    chk("R4 no dispatch with ime off", {15'd0, dispatch_o}, 16'd0);
    // R9: ime on but no boundary
    cycle(5'h1f, 5'h00, 0, 0, 1, 0, 0, 0);
    cycle(5'h1f, 5'h00, 0, 0, 0, 0, 0, 0);
    chk("R9 no boundary", {15'd0, dispatch_o}, 16'd0);
    // R3: all five pending, bit 0 first (0x0040)
    cycle(5'h1f, 5'h1f, 0, 0, 0, 0, 0, 0);
    cycle(5'h1f, 5'h00, 1, 0, 0, 0, 0, 0);
    chk("R3 top priority vector", vector_o, 16'h0040);
    chk("R7 lower bits stay", {11'd0, req_o}, 16'h001e);
    // R8: boundary while busy does not dispatch; stray acks handled by model
    idle(4);
    cycle(5'h1f, 5'h00, 1, 0, 1, 0, 0, 0);
    cycle(5'h1f, 5'h00, 1, 0, 0, 0, 0, 0);
    chk("R8 held off while busy", {15'd0, dispatch_o}, 16'd0);
    cycle(5'h1f, 5'h00, 0, 0, 0, 0, 0, 1);
    // R5: ei and di together, di wins
    cycle(5'h1f, 5'h00, 0, 0, 1, 1, 1, 0);
    chk("R5 di wins", {15'd0, ime_o}, 16'd0);
    // R3: only bit 4 enabled gives 0x0060
    cycle(5'h10, 5'h00, 0, 0, 0, 0, 1, 0);
    cycle(5'h10, 5'h00, 1, 0, 0, 0, 0, 0);
    chk("R3 lowest priority vector", vector_o, 16'h0060);
    // R7: set on the serviced bit during the dispatch cycle keeps it
    cycle(5'h10, 5'h00, 0, 0, 0, 0, 0, 1);
    idle(4);
    cycle(5'h02, 5'h02, 0, 0, 1, 0, 0, 0);
    cycle(5'h02, 5'h02, 1, 0, 0, 0, 0, 0);
    chk("R7 set beats clear", {15'd0, req_o[1]}, 16'd1);
    cycle(5'h02, 5'h00, 0, 0, 0, 0, 0, 1);
    idle(4);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] en, st;
      en = (($urandom % 8) == 0) ? 5'($urandom) : 5'h1f;
      st = (($urandom % 4) == 0) ? 5'($urandom) : 5'h00;
      cycle(en, st, 1'($urandom % 2), 1'($urandom % 2),
            ($urandom % 6) == 0, ($urandom % 14) == 0,
            ($urandom % 14) == 0, ($urandom % 5) == 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule